// File: doc/BRIEF.md
# LCD Multiplex Drive Sequencer

This block produces the digital drive timing for a segment LCD that has 24 segment lines and 4 backplane lines. It divides the incoming clock down to a frame period of 2880 clocks, or 480 clocks in the power-saving setting. Each frame is split into equal backplane phases. A phase is the time during which one backplane row is selected. The number of phases per frame depends on the multiplex mode: static (1 phase), 1:2, 1:3 or 1:4. Drive polarity inverts on every frame, so that the LCD sees no net DC.

Segment data lives in a 24-entry by 4-bit display memory that is written one entry at a time. Before each phase begins, the memory column for that phase is copied into a display latch. The segment lines are driven from this latch, so memory writes never disturb the column currently on show. Outputs are two-bit level codes for each line, not analog voltages. The bias generator that follows turns them into drive levels.

Top module: `lcd_mux_seq`

## Requirements
- R1: A synchronous reset clears the memory and latch and selects 1:4 mode with the 2880 divide. It starts at phase 0 with polarity 0, so in the first cycle after reset `frameStrobe` is 1, only backplane 0 is selected, and every segment code is 0.
- R2: `frameStrobe` is high for one cycle at the start of each frame. Consecutive pulses are 2880 cycles apart when the slow setting is 0, and 480 cycles apart when it is 1.
- R3: A frame holds N = mode+1 phases of equal length: the frame period divided by N. Phase p covers frame cycles p·len to (p+1)·len−1. The mode codes are 0 = static, 1 = 1:2, 2 = 1:3 and 3 = 1:4.
- R4: Backplane b is selected in phase g(b). In 1:4 mode g(b)=b. In 1:3 mode, g(3)=1 and g(b)=b otherwise. In 1:2 mode g(b)=b mod 2. In static mode g(b)=0, so all four backplanes are always selected.
- R5: Backplane code bits: `bpCode[2b+1]` is the select flag and `bpCode[2b]` is the frame polarity. Segment code bits: `segCode[2s+1]` is the latched on-bit and `segCode[2s]` is the frame polarity. In phase p, the on-bit of segment s is bit p of memory entry s, written as `wrData` at `wrAddr`=s. A 1 means on.
- R6: Polarity is 0 in even frames and 1 in odd frames, counted from the last restart. It is the same on every backplane and segment line.
- R7: The latch loads the next phase's column on the last cycle of the current phase. Between loads, the segment codes do not change. A memory write in that last cycle is seen only at the following load.
- R8: A configuration write (`cfgWe`) applies `cfgMode` and `cfgSlow` and restarts the sequence at phase 0 with polarity 0 and a frame strobe. It also loads column 0 into the latch from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Multiplex mode code (0 static, 1 1:2, 2 1:3, 3 1:4) |
| cfgSlow | input | 1 | 1 selects the 480-clock frame |
| wrEn | input | 1 | Display memory write enable |
| wrAddr | input | 5 | Segment index of the memory entry |
| wrData | input | 4 | Entry bits, bit p shown in phase p |
| frameStrobe | output | 1 | One-cycle pulse at frame start |
| bpCode | output | 8 | Per-backplane {select, polarity} |
| segCode | output | 48 | Per-segment {on, polarity} |

## Verification
A memory write and a latch load can land in the same clock. The bench provokes this by writing one entry exactly on the last cycle of a phase, after its expected value for the next phase has been queued from the old memory image. The next phase must show the old bit, and the phase after it the new one. A configuration restart can also meet a running frame while polarity is 1. The bench issues the restart mid-frame and expects polarity 0, phase 0 and a strobe in the very next cycle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int PH_W = 2;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_HALF   = 2'd1,
    MUX_THIRD  = 2'd2,
    MUX_QUART  = 2'd3
  } mux_mode_e;

  typedef struct packed {
    logic            restart;
    logic            load;
    logic [PH_W-1:0] nextCol;
    logic [PH_W-1:0] phase;
    logic            pol;
    logic [1:0]      mode;
    logic            slow;
    logic            frameStart;
  } seq_ctl_t;
endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int DIV_NORMAL = 2880,
  parameter int DIV_SLOW   = 480
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cfgWe,
  input  logic [1:0] cfgMode,
  input  logic     cfgSlow,
  output seq_ctl_t ctl
);
  localparam int CNT_W = $clog2(DIV_NORMAL);

  logic [1:0]      modeQ;
  logic            slowQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntEnd;
  logic [PH_W-1:0] phase;
  logic            pol;
  logic            lastCyc;
  logic            lastPhase;

  function automatic int lenOf(input logic slow, input logic [1:0] m);
    int d;
    d = slow ? DIV_SLOW : DIV_NORMAL;
    case (m)
      2'd0:    return d;
      2'd1:    return d / 2;
      2'd2:    return d / 3;
      default: return d / 4;
    endcase
  endfunction

  always_comb begin
    cntEnd    = CNT_W'(lenOf(slowQ, modeQ) - 1);
    lastCyc   = (cnt == cntEnd);
    lastPhase = (phase == PH_W'(modeQ));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MUX_QUART;
      slowQ <= 1'b0;
      cnt   <= '0;
      phase <= '0;
      pol   <= 1'b0;
    end else if (cfgWe) begin
      modeQ <= cfgMode;
      slowQ <= cfgSlow;
      cnt   <= '0;
      phase <= '0;
      pol   <= 1'b0;
    end else if (lastCyc) begin
      cnt <= '0;
      if (lastPhase) begin
        phase <= '0;
        pol   <= ~pol;
      end else begin
        phase <= phase + PH_W'(1);
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    ctl.restart    = cfgWe;
    ctl.load       = lastCyc & ~cfgWe;
    ctl.nextCol    = lastPhase ? '0 : phase + PH_W'(1);
    ctl.phase      = phase;
    ctl.pol        = pol;
    ctl.mode       = modeQ;
    ctl.slow       = slowQ;
    ctl.frameStart = (cnt == '0) && (phase == '0);
  end
endmodule

// File: rtl/lcd_seq_data.sv
module lcd_seq_data
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 24,
  parameter int NUM_BP  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  seq_ctl_t                   ctl,
  input  logic                       wrEn,
  input  logic [$clog2(NUM_SEG)-1:0] wrAddr,
  input  logic [NUM_BP-1:0]          wrData,
  output logic [2*NUM_SEG-1:0]       segCode
);
  localparam int ADDR_W = $clog2(NUM_SEG);

  logic [NUM_BP-1:0]  mem [NUM_SEG];
  logic [NUM_SEG-1:0] latchQ;
  logic [NUM_SEG-1:0] colSel;
  logic [PH_W-1:0]    colIdx;
  logic               addrOk;

  assign colIdx = ctl.restart ? '0 : ctl.nextCol;
  assign addrOk = ({1'b0, wrAddr} < (ADDR_W+1)'(NUM_SEG));

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign colSel[s]        = mem[s][colIdx];
    assign segCode[2*s+1]   = latchQ[s];
    assign segCode[2*s]     = ctl.pol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) mem[i] <= '0;
      latchQ <= '0;
    end else begin
      if (wrEn && addrOk) mem[wrAddr] <= wrData;
      if (ctl.restart || ctl.load) latchQ <= colSel;
    end
  end
endmodule

// File: rtl/lcd_seq_bpmap.sv
module lcd_seq_bpmap
  import lcd_seq_pkg::*;
#(
  parameter int NUM_BP = 4
) (
  input  seq_ctl_t            ctl,
  output logic [2*NUM_BP-1:0] bpCode
);
  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    logic [PH_W-1:0] grp;
    always_comb begin
      case (ctl.mode)
        MUX_STATIC: grp = '0;
        MUX_HALF:   grp = PH_W'(b % 2);
        MUX_THIRD:  grp = (b == 3) ? PH_W'(1) : PH_W'(b);
        default:    grp = PH_W'(b);
      endcase
    end
    assign bpCode[2*b+1] = (grp == ctl.phase);
    assign bpCode[2*b]   = ctl.pol;
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG    = 24,
  parameter int NUM_BP     = 4,
  parameter int DIV_NORMAL = 2880,
  parameter int DIV_SLOW   = 480
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfgWe,
  input  logic [1:0]                 cfgMode,
  input  logic                       cfgSlow,
  input  logic                       wrEn,
  input  logic [$clog2(NUM_SEG)-1:0] wrAddr,
  input  logic [NUM_BP-1:0]          wrData,
  output logic                       frameStrobe,
  output logic [2*NUM_BP-1:0]        bpCode,
  output logic [2*NUM_SEG-1:0]       segCode
);
  seq_ctl_t seqCtl;

  lcd_seq_ctrl #(.DIV_NORMAL(DIV_NORMAL), .DIV_SLOW(DIV_SLOW)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgSlow(cfgSlow), .ctl(seqCtl)
  );

  lcd_seq_data #(.NUM_SEG(NUM_SEG), .NUM_BP(NUM_BP)) u_data (
    .clk(clk), .rst(rst), .ctl(seqCtl), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .segCode(segCode)
  );

  lcd_seq_bpmap #(.NUM_BP(NUM_BP)) u_bpmap (
    .ctl(seqCtl), .bpCode(bpCode)
  );

  assign frameStrobe = seqCtl.frameStart;
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG    = 24,
  parameter int NUM_BP     = 4,
  parameter int DIV_NORMAL = 2880,
  parameter int DIV_SLOW   = 480
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfgWe,
  input logic                 frameStrobe,
  input logic [2*NUM_BP-1:0]  bpCode,
  input logic [2*NUM_SEG-1:0] segCode,
  input seq_ctl_t             ctl
);
  logic [15:0]        gap;
  logic [15:0]        expF;
  logic [NUM_BP-1:0]  bpSel;
  logic [NUM_SEG-1:0] segOn;

  for (genvar b = 0; b < NUM_BP; b++) begin : g_b
    assign bpSel[b] = bpCode[2*b+1];
  end
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_s
    assign segOn[s] = segCode[2*s+1];
  end

  assign expF = ctl.slow ? 16'(DIV_SLOW) : 16'(DIV_NORMAL);

  always_ff @(posedge clk) begin
    if (rst || cfgWe) gap <= '0;
    else if (frameStrobe) gap <= 16'd1;
    else gap <= gap + 16'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (frameStrobe && segOn == '0 && bpSel == NUM_BP'(1)));

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (frameStrobe && gap != '0) |-> gap == expF);

  // R2
  strobe_present_chk: assert property (@(posedge clk) disable iff (rst)
    (gap == expF) |-> frameStrobe);

  // R4
  quart_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.mode == MUX_QUART) |-> $countones(bpSel) == 1);

  // R4
  static_all_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.mode == MUX_STATIC) |-> bpSel == '1);

  // R6
  pol_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (frameStrobe && !$past(rst) && !$past(cfgWe)) |-> bpCode[0] != $past(bpCode[0]));

  // R6
  pol_match_chk: assert property (@(posedge clk) disable iff (rst)
    bpCode[0] == segCode[0]);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctl.load) && !$past(cfgWe)) |-> $stable(segOn));
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(
  .NUM_SEG(NUM_SEG), .NUM_BP(NUM_BP),
  .DIV_NORMAL(DIV_NORMAL), .DIV_SLOW(DIV_SLOW)
) u_chk (
  .clk(clk), .rst(rst), .cfgWe(cfgWe), .frameStrobe(frameStrobe),
  .bpCode(bpCode), .segCode(segCode), .ctl(seqCtl)
);

// File: tb/sim_lcd_mux_seq.sv
module sim_lcd_mux_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 24;
  localparam int NBP  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWe = 1'b0;
  logic [1:0] cfgMode = 2'd3;
  logic cfgSlow = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic frameStrobe;
  logic [2*NBP-1:0] bpCode;
  logic [2*NSEG-1:0] segCode;

  lcd_mux_seq u0 (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgSlow(cfgSlow),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameStrobe(frameStrobe), .bpCode(bpCode), .segCode(segCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int cyc;
    logic [2*NBP-1:0] bp;
    logic [2*NSEG-1:0] seg;
    logic stb;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  logic [3:0] img [NSEG];
  int curMode = 3;
  int curSlow = 0;

  always @(posedge clk) begin
    if (rst || cfgWe) cyc <= 0;
    else cyc <= cyc + 1;
  end

  function automatic int grpOf(int m, int b);
    if (m == 0) return 0;
    if (m == 1) return b % 2;
    if (m == 2) return (b == 3) ? 1 : b;
    return b;
  endfunction

  task automatic pushAt(int t, string tag);
    item_t it;
    int f, n, len, r, p, pol;
    f = curSlow ? 480 : 2880;
    n = curMode + 1;
    len = f / n;
    r = t % f;
    p = r / len;
    pol = (t / f) % 2;
    it.cyc = t;
    it.tag = tag;
    it.stb = (r == 0);
    for (int b = 0; b < NBP; b++) begin
      it.bp[2*b+1] = (grpOf(curMode, b) == p);
      it.bp[2*b] = pol[0];
    end
    for (int s = 0; s < NSEG; s++) begin
      it.seg[2*s+1] = img[s][p];
      it.seg[2*s] = pol[0];
    end
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      if (q[0].cyc == cyc) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (bpCode !== it.bp || segCode !== it.seg || frameStrobe !== it.stb) begin
          failures++;
          $display("FAIL %s cyc=%0d actual bp=%h seg=%h stb=%b expected bp=%h seg=%h stb=%b",
                   it.tag, cyc, bpCode, segCode, frameStrobe, it.bp, it.seg, it.stb);
        end
      end else if (q[0].cyc < cyc) begin
        item_t it;
        it = q.pop_front();
        checks++;
        failures++;
        $display("FAIL %s missed sample actual cyc=%0d expected cyc=%0d", it.tag, cyc, it.cyc);
      end
    end
  end

  task automatic waitUntil(int t);
    while (cyc != t) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic doCfg(int m, int s);
    @(posedge clk);
    #1;
    cfgWe = 1'b1;
    cfgMode = 2'(m);
    cfgSlow = s[0];
    @(posedge clk);
    #1;
    cfgWe = 1'b0;
    curMode = m;
    curSlow = s;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    finishRun();
  end

  initial begin
    for (int s = 0; s < NSEG; s++) img[s] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset state, cycle 0 and the following cycle
    pushAt(0, "R1");
    pushAt(1, "R1");
    // fill memory during cycles 0..23 (phase 0 of frame 0)
    for (int s = 0; s < NSEG; s++) begin
      wrEn = 1'b1;
      wrAddr = 5'(s);
      wrData = 4'((s * 7 + 3) % 16);
      img[s] = 4'((s * 7 + 3) % 16);
      @(posedge clk);
      #1;
    end
    wrEn = 1'b0;
    // R3 R4 R5: 1:4 normal phase boundaries
    pushAt(720, "R5");
    pushAt(1439, "R3");
    pushAt(2879, "R2");
    // R2 R6: second frame, inverted polarity
    pushAt(2880, "R6");
    pushAt(2900, "R4");
    drain();
    // R8: restart mid-frame while polarity is 1
    waitUntil(2950);
    doCfg(3, 1);
    pushAt(0, "R8");
    pushAt(119, "R3");
    pushAt(120, "R4");
    pushAt(240, "R5");
    pushAt(360, "R5");
    pushAt(479, "R2");
    pushAt(480, "R2");
    pushAt(600, "R6");
    drain();
    // R7: write on the last cycle of phase 0 meets the latch load
    doCfg(3, 1);
    pushAt(150, "R7");
    waitUntil(119);
    wrEn = 1'b1;
    wrAddr = 5'd5;
    wrData = 4'b1001;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    img[5] = 4'b1001;
    pushAt(250, "R7");
    pushAt(370, "R7");
    drain();
    // R4: 1:3 sharing, slow
    doCfg(2, 1);
    pushAt(0, "R4");
    pushAt(160, "R4");
    pushAt(320, "R3");
    pushAt(479, "R3");
    pushAt(480, "R6");
    drain();
    // R4: 1:2 sharing, slow
    doCfg(1, 1);
    pushAt(0, "R4");
    pushAt(240, "R4");
    pushAt(480, "R2");
    drain();
    // R4: static mode, slow
    doCfg(0, 1);
    pushAt(0, "R4");
    pushAt(100, "R5");
    pushAt(480, "R6");
    drain();
    // R2 R3: 1:3 at normal divide
    doCfg(2, 0);
    pushAt(960, "R3");
    pushAt(2879, "R2");
    pushAt(2880, "R2");
    drain();
    finishRun();
  end
endmodule